// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block derives the bit timing for an I2C master from the peripheral clock. Two divisors are cascaded. A prescaler gives a single-cycle module-clock enable (`modTick`) once every CDF+1 peripheral clocks. A period counter driven by that enable splits each SCL bit into four equal quarters and fires a one-cycle strobe at each quarter boundary. The bus sequencer uses these strobes to drive SCL low, change SDA, release SCL high and sample SDA. One bit lasts 8*SCGD+20 module-clock ticks, which is always a multiple of four, so each quarter is exactly 2*SCGD+5 ticks long.

The divisors come from an 8-bit setting word that is written through `cfgWe`/`cfgData`. A new setting is held back until the running bit period ends, so a bit on the wire is never cut short. `sclOut` is a reference SCL level that follows the low and high strobes. It lets the sequencer, or an observer, see the phase of the bit.

Top module: `sclRateGen`

## Requirements
- R1: While `rstN` is low, `sclOut` is 1. Reset loads the setting CDF=0, SCGD=0, so the first period after reset lasts 20 peripheral clocks.
- R2: `modTick` is high for exactly one peripheral clock in every CDF+1.
- R3: In `cfgData`, bits [1:0] hold CDF and bits [7:2] hold SCGD.
- R4: Consecutive `sclLowStb` pulses are (CDF+1)*(8*SCGD+20) peripheral clocks apart.
- R5: With Q = 2*SCGD+5, the strobes `sdaDriveStb`, `sclHighStb` and `sdaSampleStb` come Q, 2Q and 3Q ticks after `sclLowStb`, that is (CDF+1)*Q, 2(CDF+1)*Q and 3(CDF+1)*Q peripheral clocks.
- R6: The four phase strobes last one cycle each, never two at once, and each one coincides with `modTick`.
- R7: `sclOut` goes to 0 in the cycle after `sclLowStb` and to 1 in the cycle after `sclHighStb`. It is therefore 0 at `sdaDriveStb` and 1 at `sdaSampleStb`.
- R8: A write does not disturb the running period, whose strobes keep the old spacing. The first tick under the new setting comes CDF_new+1 clocks after the last tick of the old period, and that tick carries `sclLowStb`.
- R9: An SCGD field of 63 is taken as 62, giving a period of 516 ticks.
- R10: If several writes fall in one period, only the last one takes effect at the period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for the setting word |
| cfgData | input | 8 | Setting word: SCGD in [7:2], CDF in [1:0] |
| modTick | output | 1 | Module-clock enable pulse |
| sclLowStb | output | 1 | Start of bit: SCL is pulled low |
| sdaDriveStb | output | 1 | Middle of the low phase: SDA may change |
| sclHighStb | output | 1 | SCL is released high |
| sdaSampleStb | output | 1 | Middle of the high phase: SDA is sampled |
| sclOut | output | 1 | Reference SCL level |

## Verification
The checks assume a continuously running peripheral clock that is already below the module-clock limit at CDF+1. They also assume that `cfgData` is only looked at while `cfgWe` is high, so X or garbage on it at other times is harmless. The stimulus writes the setting only at falling clock edges and holds the write for one cycle. It draws CDF and SCGD from their full legal ranges and adds the reserved SCGD value 63 and double writes within one period. Timing is measured between strobes that are observed at the ports, so every check works no matter where the setting change lands inside a period.

// File: rtl/sclDivPkg.sv
package sclDivPkg;
  // progress strobes from the datapath to the control
  typedef struct packed {
    logic tick;  // module-clock enable
    logic wrap;  // last tick of the bit period
  } pathStb_t;

  // quarter-phase strobes for the bus sequencer
  typedef struct packed {
    logic sclLow;
    logic sdaDrive;
    logic sclHigh;
    logic sdaSample;
  } phaseStb_t;
endpackage

// File: rtl/sclDivPath.sv
module sclDivPath
  import sclDivPkg::*;
#(
  parameter int CDF_W = 2,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CDF_W-1:0] cdf,
  input  logic [CNT_W-1:0] lastCnt,
  output pathStb_t         stb,
  output logic [CNT_W-1:0] cnt
);
  logic [CDF_W-1:0] divCnt;

  always_comb begin
    stb.tick = (divCnt == cdf);
    stb.wrap = stb.tick && (cnt == lastCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      cnt    <= '0;
    end else begin
      divCnt <= stb.tick ? '0 : divCnt + 1'b1;
      if (stb.wrap)
        cnt <= '0;
      else if (stb.tick)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sclDivCtrl.sv
module sclDivCtrl
  import sclDivPkg::*;
#(
  parameter int CDF_W    = 2,
  parameter int SCGD_W   = 6,
  parameter int CNT_W    = SCGD_W + 4,
  parameter int RST_CDF  = 0,
  parameter int RST_SCGD = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [CDF_W+SCGD_W-1:0] cfgData,
  input  pathStb_t                stb,
  input  logic [CNT_W-1:0]        cnt,
  output logic [CDF_W-1:0]        actCdf,
  output logic [CNT_W-1:0]        lastCnt,
  output phaseStb_t               phase,
  output logic                    sclOut
);
  localparam int SCGD_MAX = (1 << SCGD_W) - 2;

  logic [CDF_W-1:0]  pendCdf;
  logic [SCGD_W-1:0] pendScgd, actScgd, wrScgd;
  logic [CNT_W-1:0]  quarter, half, threeQ;

  always_comb begin
    wrScgd  = (cfgData[CDF_W +: SCGD_W] == '1) ? SCGD_W'(SCGD_MAX)
                                                : cfgData[CDF_W +: SCGD_W];
    quarter = CNT_W'({actScgd, 1'b0}) + CNT_W'(5);
    half    = quarter << 1;
    threeQ  = half + quarter;
    lastCnt = (quarter << 2) - 1'b1;
    phase.sclLow    = stb.tick && (cnt == '0);
    phase.sdaDrive  = stb.tick && (cnt == quarter);
    phase.sclHigh   = stb.tick && (cnt == half);
    phase.sdaSample = stb.tick && (cnt == threeQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCdf  <= CDF_W'(RST_CDF);
      pendScgd <= SCGD_W'(RST_SCGD);
      actCdf   <= CDF_W'(RST_CDF);
      actScgd  <= SCGD_W'(RST_SCGD);
      sclOut   <= 1'b1;
    end else begin
      if (cfgWe) begin
        pendCdf  <= cfgData[CDF_W-1:0];
        pendScgd <= wrScgd;
      end
      if (stb.wrap) begin
        actCdf  <= pendCdf;
        actScgd <= pendScgd;
      end
      if (phase.sclLow)
        sclOut <= 1'b0;
      else if (phase.sclHigh)
        sclOut <= 1'b1;
    end
  end
endmodule

// File: rtl/sclRateGen.sv
module sclRateGen
  import sclDivPkg::*;
#(
  parameter int CDF_W    = 2,
  parameter int SCGD_W   = 6,
  parameter int RST_CDF  = 0,
  parameter int RST_SCGD = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [CDF_W+SCGD_W-1:0] cfgData,
  output logic                    modTick,
  output logic                    sclLowStb,
  output logic                    sdaDriveStb,
  output logic                    sclHighStb,
  output logic                    sdaSampleStb,
  output logic                    sclOut
);
  localparam int CNT_W = SCGD_W + 4;

  pathStb_t         pathStb;
  phaseStb_t        phase;
  logic [CNT_W-1:0] cnt, lastCnt;
  logic [CDF_W-1:0] actCdf;

  sclDivPath #(.CDF_W(CDF_W), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .cdf(actCdf), .lastCnt(lastCnt),
    .stb(pathStb), .cnt(cnt)
  );

  sclDivCtrl #(.CDF_W(CDF_W), .SCGD_W(SCGD_W), .CNT_W(CNT_W),
               .RST_CDF(RST_CDF), .RST_SCGD(RST_SCGD)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .stb(pathStb), .cnt(cnt), .actCdf(actCdf), .lastCnt(lastCnt),
    .phase(phase), .sclOut(sclOut)
  );

  assign modTick      = pathStb.tick;
  assign sclLowStb    = phase.sclLow;
  assign sdaDriveStb  = phase.sdaDrive;
  assign sclHighStb   = phase.sclHigh;
  assign sdaSampleStb = phase.sdaSample;
endmodule

// File: rtl/sclRateGenChk.sv
module sclRateGenChk #(
  parameter int CDF_W = 2
) (
  input logic clk,
  input logic rstN,
  input logic modTick,
  input logic sclLowStb,
  input logic sdaDriveStb,
  input logic sclHighStb,
  input logic sdaSampleStb,
  input logic sclOut
);
  localparam int CDF_MAX = (1 << CDF_W) - 1;

  logic [CDF_W:0] gapCnt;
  always_ff @(posedge clk) begin
    if (!rstN || modTick) gapCnt <= '0;
    else                  gapCnt <= gapCnt + 1'b1;
  end

  // R6
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sclLowStb, sdaDriveStb, sclHighStb, sdaSampleStb}));

  // R6
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclLowStb || sdaDriveStb || sclHighStb || sdaSampleStb) |-> modTick);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(gapCnt) <= CDF_MAX);

  // R7
  scl_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclLowStb |=> !sclOut);

  // R7
  scl_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclHighStb |=> sclOut);

  // R7
  drive_while_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveStb |-> !sclOut);

  // R7
  sample_while_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaSampleStb |-> sclOut);
endmodule

bind sclRateGen sclRateGenChk #(.CDF_W(CDF_W)) uChk (
  .clk(clk), .rstN(rstN), .modTick(modTick), .sclLowStb(sclLowStb),
  .sdaDriveStb(sdaDriveStb), .sclHighStb(sclHighStb),
  .sdaSampleStb(sdaSampleStb), .sclOut(sclOut)
);

// File: tb/tb_sclRateGen.sv
module tb_sclRateGen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgData = '0;
  logic modTick, sclLowStb, sdaDriveStb, sclHighStb, sdaSampleStb, sclOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sclRateGen dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .modTick(modTick), .sclLowStb(sclLowStb), .sdaDriveStb(sdaDriveStb),
    .sclHighStb(sclHighStb), .sdaSampleStb(sdaSampleStb), .sclOut(sclOut)
  );

  function automatic int quarterOf(int g);
    return 2 * (g > 62 ? 62 : g) + 5;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3: SCGD in bits [7:2], CDF in bits [1:0]
  task automatic writeCfg(int c, int g);
    @(negedge clk);
    cfgData = {g[5:0], c[1:0]};
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitLow();
    do @(negedge clk); while (!sclLowStb);
  endtask

  // sync to a sclLow strobe, then measure one full period
  task automatic runPeriod(int c, int g, string req);
    int q = quarterOf(g);
    int t0, tD, tH, tS, lastTick;
    int badGap = 0, badScl = 0;
    bit prevHigh = 0, prevLow = 0;
    waitLow();
    t0 = cyc; lastTick = cyc; tD = -1; tH = -1; tS = -1;
    prevLow = 1;
    forever begin
      @(negedge clk);
      if (prevHigh && !sclOut) badScl++;
      if (prevLow && sclOut) badScl++;
      prevHigh = sclHighStb; prevLow = sclLowStb;
      if (modTick) begin
        if (cyc - lastTick != c + 1) badGap++;
        lastTick = cyc;
      end
      if (sdaDriveStb)  tD = cyc;
      if (sclHighStb)   tH = cyc;
      if (sdaSampleStb) tS = cyc;
      if (sclLowStb) break;
    end
    check(badGap == 0, {req, " R2 tick spacing"}, badGap, 0);
    check(cyc - t0 == (c + 1) * 4 * q, {req, " R4 period"}, cyc - t0, (c + 1) * 4 * q);
    check(tD - t0 == (c + 1) * q, {req, " R5 drive point"}, tD - t0, (c + 1) * q);
    check(tH - t0 == 2 * (c + 1) * q, {req, " R5 high point"}, tH - t0, 2 * (c + 1) * q);
    check(tS - t0 == 3 * (c + 1) * q, {req, " R5 sample point"}, tS - t0, 3 * (c + 1) * q);
    check(badScl == 0, {req, " R7 scl level"}, badScl, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 1234;
    int c0, g0, c1, g1, t0, tS, tL, q0;
    void'($urandom(seed));
    repeat (3) begin
      @(negedge clk);
      // R1: sclOut held high in reset
      check(sclOut == 1'b1, "R1 reset sclOut", sclOut, 1);
    end
    rstN = 1'b1;
    // R1: reset setting gives a 20-cycle period
    runPeriod(0, 0, "R1 reset setting");

    // directed corners and R3 field placement
    writeCfg(3, 0);  runPeriod(3, 0,  "R3 cdf3");
    writeCfg(0, 5);  runPeriod(0, 5,  "R3 scgd5");
    writeCfg(1, 62); runPeriod(1, 62, "R4 max scgd");
    // R9: SCGD field 63 treated as 62
    writeCfg(0, 63); runPeriod(0, 63, "R9 scgd63");

    // R10: two writes in one period, last wins
    waitLow();
    writeCfg(3, 40);
    writeCfg(2, 3);
    runPeriod(2, 3, "R10 last write");

    // R8: write mid-period keeps the old timing
    c0 = 2; g0 = 4; c1 = 1; g1 = 9;
    writeCfg(c0, g0);
    waitLow();
    t0 = cyc;
    writeCfg(c1, g1);
    q0 = quarterOf(g0);
    do @(negedge clk); while (!sdaSampleStb);
    tS = cyc;
    check(tS - t0 == 3 * (c0 + 1) * q0, "R8 old sample point", tS - t0, 3 * (c0 + 1) * q0);
    waitLow();
    tL = cyc;
    check(tL - t0 == (4 * q0 - 1) * (c0 + 1) + c1 + 1, "R8 switch point",
          tL - t0, (4 * q0 - 1) * (c0 + 1) + c1 + 1);
    runPeriod(c1, g1, "R8 new setting");

    // constrained random settings
    for (int i = 0; i < 8; i++) begin
      int c = $urandom % 4;
      int g = $urandom % 63;
      writeCfg(c, g);
      runPeriod(c, g, "R4 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule